// File: doc/BRIEF.md
# Capture Value Buffer with Loss Flag

This block sits between a capture unit and the register that software reads. Each capture strobe carries a 32-bit counter value and writes it into a first-in first-out buffer of 16 entries. Each read strobe removes the oldest entry. The read data output always shows the oldest stored value. When the buffer is empty, the output keeps the value removed by the most recent read.

The buffer does not overwrite old data. A capture that arrives while all slots are occupied is thrown away, and a sticky loss flag records that it happened. A single clear strobe empties the buffer and lowers the loss flag. This clear strobe is the one-cycle pulse that a self-clearing command bit produces. Full, empty and fill-level outputs let software pace its reads. The block uses one clock and an active-low asynchronous reset.

Top module: `cap_fifo`

## Requirements
- R1: While reset is asserted and after it is released, empty_o is 1, full_o is 0, drop_o is 0, level_o is 0 and rd_data_o is 0.
- R2: A capture (cap_i=1) taken while the buffer is not full stores cap_data_i. In the next cycle level_o is one higher. full_o is 1 exactly when level_o is 16, and empty_o is 1 exactly when level_o is 0.
- R3: Values leave in the order they arrived. While the buffer is not empty, rd_data_o shows the oldest stored value. A read (rd_i=1) on a non-empty buffer removes that value, and level_o is one lower in the next cycle.
- R4: A capture taken while the buffer is full, with no read in the same cycle, is discarded. The stored values and level_o stay unchanged.
- R5: Every discarded capture sets drop_o in the next cycle. drop_o then stays 1 until a clear.
- R6: A clear (clr_i=1) makes level_o 0, empty_o 1 and drop_o 0 in the next cycle. It takes priority over a capture or a read in the same cycle: that capture is not stored and that read removes nothing.
- R7: A read while the buffer is empty leaves level_o unchanged. It also leaves rd_data_o unchanged, and rd_data_o keeps holding the value removed by the most recent read.
- R8: A capture and a read in the same cycle while the buffer is full are both accepted. The oldest value is removed, the new value is stored, level_o stays 16, and drop_o is not set.
- R9: A capture and a read in the same cycle on a buffer that is neither empty nor full leave level_o unchanged and keep arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_i | input | 1 | Capture strobe, stores cap_data_i |
| cap_data_i | input | 32 | Captured counter value |
| rd_i | input | 1 | Read strobe, removes the oldest entry |
| clr_i | input | 1 | Clear strobe, empties the buffer and lowers drop_o |
| rd_data_o | output | 32 | Oldest entry, or the last removed value when empty |
| level_o | output | 5 | Number of stored entries, 0 to 16 |
| full_o | output | 1 | Buffer holds 16 entries |
| empty_o | output | 1 | Buffer holds no entries |
| drop_o | output | 1 | Sticky flag: a capture was discarded |

## Verification
On every cycle the assertions check the following:
- the level never exceeds the depth;
- full and empty are never high together;
- a discarded capture raises the loss flag, which then stays high;
- a clear always leaves the buffer empty with the flag low;
- a read on an empty buffer or a simultaneous capture and read on a full buffer leaves the level as it was.

Only the bench scenarios can show data ordering. These include the values that survive a burst of discarded captures, the exact value held on the output once the buffer has drained, and correct pointer wrap-around over long random sequences of mixed captures, reads and clears.

// File: rtl/cap_fifo_pkg.sv
package cap_fifo_pkg;
  localparam int unsigned CAP_W     = 32;
  localparam int unsigned CAP_DEPTH = 16;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;
endpackage

// File: rtl/cap_fifo_ctrl.sv
module cap_fifo_ctrl
  import cap_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = CAP_DEPTH,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          rd_i,
  input  logic          clr_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic          pop_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          drop_o
);
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          drop_q;
  logic          push, pop, discard;
  fifo_op_e      op;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // clear wins over everything; a pop frees room for a same-cycle push
  assign pop     = rd_i && !empty_o && !clr_i;
  assign push    = cap_i && !clr_i && (!full_o || pop);
  assign discard = cap_i && !clr_i && full_o && !pop;
  assign op      = fifo_op_e'({pop, push});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      drop_q <= 1'b0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      if (push) wptr_q <= ptr_inc(wptr_q);
      if (pop)  rptr_q <= ptr_inc(rptr_q);
      unique case (op)
        OP_PUSH: cnt_q <= cnt_q + 1'b1;
        OP_POP:  cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (discard) drop_q <= 1'b1;
    end
  end

  assign we_o    = push;
  assign waddr_o = wptr_q;
  assign raddr_o = rptr_q;
  assign pop_o   = pop;
  assign level_o = cnt_q;
  assign drop_o  = drop_q;

  // R2
  level_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));
  // R2
  full_empty_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  // R5
  drop_on_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !rd_i && !clr_i && full_o) |=> drop_o);
  // R5
  drop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && !clr_i) |=> drop_o);
  // R6
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (empty_o && !drop_o && level_o == '0));
  // R7
  empty_read_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !cap_i && !clr_i && empty_o) |=> (empty_o && $stable(level_o)));
  // R8
  full_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && rd_i && !clr_i && full_o && !drop_o) |=> (full_o && !drop_o));
endmodule

// File: rtl/cap_fifo_store.sv
module cap_fifo_store
  import cap_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = CAP_W,
  parameter int unsigned DEPTH = CAP_DEPTH,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  input  logic             pop_i,
  input  logic             empty_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] last_q;
  logic [WIDTH-1:0] head;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign head = mem_q[raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= '0;
    else if (pop_i) last_q <= head;
  end

  // drained buffer keeps showing the value software took last
  assign rdata_o = empty_i ? last_q : head;

  // R7
  hold_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo
  import cap_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = CAP_W,
  parameter int unsigned DEPTH = CAP_DEPTH,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] cap_data_i,
  input  logic             rd_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [CW-1:0]    level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o
);
  logic          we, pop;
  logic [AW-1:0] waddr, raddr;

  cap_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap_i),
    .rd_i    (rd_i),
    .clr_i   (clr_i),
    .we_o    (we),
    .waddr_o (waddr),
    .raddr_o (raddr),
    .pop_o   (pop),
    .level_o (level_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .drop_o  (drop_o)
  );

  cap_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (cap_data_i),
    .raddr_i (raddr),
    .pop_i   (pop),
    .empty_i (empty_o),
    .rdata_o (rd_data_o)
  );
endmodule

// File: tb/cap_fifo_tb.sv
module cap_fifo_tb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cap_i = 1'b0, rd_i = 1'b0, clr_i = 1'b0;
  logic [31:0] cap_data_i = '0;
  logic [31:0] rd_data_o;
  logic [4:0]  level_o;
  logic        full_o, empty_o, drop_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mq[$];
  logic [31:0] m_last = '0;
  logic        m_drop = 1'b0;

  always #10 clk = ~clk;

  cap_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cap_i(cap_i), .cap_data_i(cap_data_i),
    .rd_i(rd_i), .clr_i(clr_i), .rd_data_o(rd_data_o), .level_o(level_o),
    .full_o(full_o), .empty_o(empty_o), .drop_o(drop_o)
  );

  function automatic logic [31:0] exp_data();
    return (mq.size() != 0) ? mq[0] : m_last;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "rd_data", rd_data_o, exp_data());
    chk(tag, "level", 32'(level_o), 32'(mq.size()));
    chk(tag, "full", 32'(full_o), 32'(mq.size() == DEPTH));
    chk(tag, "empty", 32'(empty_o), 32'(mq.size() == 0));
    chk(tag, "drop", 32'(drop_o), 32'(m_drop));
  endtask

  task automatic step(bit c, logic [31:0] d, bit r, bit k, string tag);
    bit was_full, do_rd;
    @(negedge clk);
    cap_i = c; cap_data_i = d; rd_i = r; clr_i = k;
    if (k) begin
      mq.delete();
      m_drop = 1'b0;
    end else begin
      was_full = (mq.size() == DEPTH);
      do_rd = r && (mq.size() != 0);
      if (do_rd) m_last = mq.pop_front();
      if (c && (!was_full || do_rd)) mq.push_back(d);
      else if (c) m_drop = 1'b1;
    end
    @(posedge clk);
    #2;
    cap_i = 1'b0; rd_i = 1'b0; clr_i = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #4ms;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #25;
    check_all("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check_all("R1");

    // R2: fill to the top
    for (int i = 0; i < DEPTH; i++) step(1, 32'hA000_0000 + i, 0, 0, "R2");
    // R4 / R5: overflow attempts
    step(1, 32'hDEAD_0001, 0, 0, "R4");
    step(1, 32'hDEAD_0002, 0, 0, "R5");
    step(0, 0, 0, 0, "R5");
    // R8: swap while full
    step(1, 32'hB000_0001, 1, 0, "R8");
    // R3: drain in order
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, "R3");
    // R7: reads on empty
    step(0, 0, 1, 0, "R7");
    step(0, 0, 1, 0, "R7");
    // R6: clear beats capture and read
    step(1, 32'hC000_0001, 0, 0, "R6");
    step(1, 32'hC000_0002, 0, 0, "R6");
    step(1, 32'hC000_0003, 1, 1, "R6");
    step(0, 0, 1, 0, "R6");
    // R9: simultaneous traffic mid-level
    step(1, 32'hD000_0001, 0, 0, "R9");
    step(1, 32'hD000_0002, 0, 0, "R9");
    step(1, 32'hD000_0003, 1, 0, "R9");
    step(1, 32'hD000_0004, 1, 0, "R9");
    // R8: full swap with drop clear beforehand
    step(0, 0, 0, 1, "R8");
    for (int i = 0; i < DEPTH; i++) step(1, 32'hE000_0000 + i, 0, 0, "R8");
    step(1, 32'hE100_0000, 1, 0, "R8");

    // random mix, biased to cross full and empty often
    for (int i = 0; i < 4000; i++) begin
      int ph = (i / 200) % 2;
      bit c = ($urandom_range(99) < (ph ? 70 : 35));
      bit r = ($urandom_range(99) < (ph ? 35 : 70));
      bit k = ($urandom_range(199) == 0);
      step(c, $urandom(), r, k, "R9");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule